// File: doc/BRIEF.md
# SPI Port Controller with Collision and Mode-Fault Detection

This block is a byte-wide serial peripheral that works either as the bus master, generating the serial clock from the system clock, or as a slave clocked by an external master. One transfer moves eight bits out, most significant bit first, while eight bits come in on the opposite data line. All four combinations of clock polarity and clock phase are supported, and both ends of a link must use the same one.

Software reaches the block through a small register port of three registers: control, status and data. A write to the data register while the block is idle loads the outgoing byte. In master mode that write also starts the transfer. A read of the data register returns the last byte received. Two error conditions are detected. Writing the data register during a transfer is flagged as a collision, and the byte already being shifted is not changed. Another device pulling the master's select input low is flagged as a mode fault, which demotes the block and releases its pins. Every register access completes in the cycle it is presented and is never stalled, so the register port has no ready signal and no back-pressure.

In slave mode the block samples the incoming clock with the system clock. The external clock's half period must therefore be at least two system clocks.

Top module: `spi_port_ctl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0, and the clock, MOSI and MISO output enables are low. Control bits: 0 enable, 1 master, 2 clock polarity, 3 clock phase, 5:4 rate, 6 select-ignore. Status bits: 0 done, 1 collision, 2 fault. Data is at address 2.
- R2: A master write to the data register exchanges one byte, MSB first, in both directions. Reading address 2 afterwards returns the byte the far end sent, and the done bit (status bit 0) sets.
- R3: The master's serial clock rests at the level of the polarity bit. During a byte it makes exactly 16 transitions and then returns to that level.
- R4: Clock edges of a byte are numbered 0 to 15. With phase 0, data is valid before edge 0 and is sampled on even edges. With phase 1, data changes on even edges and is sampled on odd edges.
- R5: Rate values 0, 1, 2 and 3 give a half period of 1, 2, 8 and 16 system clocks. The done flag is visible 16 half periods plus one clock after the clock edge that accepts the data write.
- R6: A slave drives its MISO enable only while it is enabled and its select input is low.
- R7: In slave mode the rate field has no effect. The slave follows the master's clock at whatever rate the master uses.
- R8: A phase-0 slave handles one byte per low period of select and ignores clock edges after that byte until select goes high. A phase-1 slave keeps transferring bytes back to back while select stays low.
- R9: Writing the data register during a transfer sets the collision bit (status bit 1). The byte in progress is completed unchanged, and the written value is discarded.
- R10: While the block is an enabled master, a low select input sets the fault bit (status bit 2), clears the enable and master bits, drops the clock and MOSI enables and aborts the byte without setting done.
- R11: With the select-ignore bit set, a low select input on a master causes no fault and the transfer completes.
- R12: A status flag clears only after a status read followed by a data-register access. A data access with no status read before it leaves the flags set.
- R13: The irq_o output is high whenever the done or fault bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from reg_addr) |
| irq_o | output | 1 | Level request: done or fault |
| ss_n_i | input | 1 | Select input, active low |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | MISO output enable |

## Verification
A master instance is linked to a second instance acting as slave. Every combination of clock polarity, clock phase and rate is swept, each with two byte pairs, and the slave's rate field is set differently from the master's. The sweep separates the four edge orderings by reconstructing the master's outgoing bits from its own pins at the edges R4 names. It separates the four rates by the exact cycle count to done, and it separates a correct exchange from a one-sided one by checking both received bytes. Directed runs then cover select framing in each phase, a collision written mid-byte, a fault raised mid-byte, suppression of that fault, and the exact order of the flag-clearing sequence.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // control layout, bit 0 upward: en, mstr, cpol, cpha, rate[1:0], ss_off
  typedef struct packed {
    logic       ss_off;
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       mstr;
    logic       en;
  } cfg_t;

  // status layout, bit 0 upward: done, wcol, modf
  typedef struct packed {
    logic modf;
    logic wcol;
    logic done;
  } flags_t;

  function automatic int unsigned half_period(input logic [1:0] r);
    case (r)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_ctl_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb lim = CNT_W'(half_period(rate) - 1);

  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R5: every rate above the fastest leaves at least one idle clock between ticks
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && rate != 2'd0) |=> !tick);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpha,
  input  logic             run,
  input  logic             edge_ev,
  input  logic             load,
  input  logic [NBITS-1:0] load_data,
  input  logic             present,
  input  logic             in_bit,
  output logic             out_bit,
  output logic             last_edge,
  output logic             done,
  output logic             mid,
  output logic [NBITS-1:0] rx_data
);
  localparam int NEDGE = 2 * NBITS;
  localparam int EC_W  = $clog2(NEDGE);

  logic [EC_W-1:0]  ecnt_q;
  logic [NBITS-1:0] sreg_q;
  logic [NBITS-1:0] rx_q;
  logic             out_q;
  logic             done_q;
  logic             step;
  logic             smp;

  assign step      = run && edge_ev;
  assign smp       = (ecnt_q[0] == cpha);
  assign last_edge = step && (ecnt_q == EC_W'(NEDGE - 1));
  assign mid       = (ecnt_q != '0);
  assign out_bit   = out_q;
  assign done      = done_q;
  assign rx_data   = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      sreg_q <= '0;
      rx_q   <= '0;
      out_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_edge;
      if (!run)      ecnt_q <= '0;
      else if (step) ecnt_q <= last_edge ? '0 : ecnt_q + 1'b1;

      if (load)             sreg_q <= load_data;
      else if (step && smp) sreg_q <= {sreg_q[NBITS-2:0], in_bit};

      if (present)                       out_q <= load ? load_data[NBITS-1] : sreg_q[NBITS-1];
      else if (step && !smp && !last_edge) out_q <= sreg_q[NBITS-1];

      if (last_edge) rx_q <= smp ? {sreg_q[NBITS-2:0], in_bit} : sreg_q;
    end
  end

  // R2: the closing edge of a byte returns the edge counter to its start
  a_r2_edge_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last_edge |=> !mid);
  // R2: completion is a single-cycle event
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          done_ev,
  input  logic          ss_n_i,
  input  logic [DW-1:0] rx_data,
  output cfg_t          cfg,
  output logic          load,
  output logic          modf_ev,
  output logic          irq
);
  localparam int CFG_W = $bits(cfg_t);

  cfg_t   cfg_q;
  flags_t flg_q;
  flags_t seen_q;
  logic   wr_ctrl, wr_data, rd_stat, acc_data, wcol_ev;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign rd_stat  = reg_rd && (reg_addr == A_STAT);
  assign acc_data = (reg_wr || reg_rd) && (reg_addr == A_DATA);

  assign modf_ev = cfg_q.en && cfg_q.mstr && !cfg_q.ss_off && !ss_n_i;
  assign wcol_ev = wr_data && busy;
  assign load    = wr_data && !busy && !modf_ev;
  assign cfg     = cfg_q;
  assign irq     = flg_q.done || flg_q.modf;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'(cfg_q);
      A_STAT:  reg_rdata = DW'(flg_q);
      A_DATA:  reg_rdata = rx_data;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flg_q  <= '0;
      seen_q <= '0;
    end else begin
      if (modf_ev) begin
        cfg_q.en   <= 1'b0;
        cfg_q.mstr <= 1'b0;
      end else if (wr_ctrl) begin
        cfg_q <= cfg_t'(reg_wdata[CFG_W-1:0]);
      end

      if (rd_stat)       seen_q <= flg_q;
      else if (acc_data) seen_q <= '0;

      flg_q <= flags_t'((acc_data ? (flg_q & ~seen_q) : flg_q) | {modf_ev, wcol_ev, done_ev});
    end
  end

  // R10: a fault demotes the block and leaves the fault bit standing
  a_r10_modf_demotes: assert property (@(posedge clk) disable iff (!rst_n)
    modf_ev |=> (!cfg_q.en && !cfg_q.mstr && flg_q.modf));
  // R9: a data write during a transfer is recorded as a collision
  a_r9_wcol_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> flg_q.wcol);
  // R12: a data access with nothing seen by a status read keeps done set
  a_r12_no_blind_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_data && flg_q.done && !seen_q.done) |=> flg_q.done);
endmodule

// File: rtl/spi_port_ctl.sv
module spi_port_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DW     = 8,
  parameter int RCNT_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o,
  input  logic          ss_n_i,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe
);
  cfg_t            cfg;
  logic            load, modf_ev, busy;
  logic            tick, run, step_ev, present, in_bit;
  logic            out_bit, last_edge, done, mid;
  logic [DW-1:0]   rx_data;
  logic            m_mode, s_sel, start, s_fall, abort;
  logic            m_busy_q, sck_q, sck_prev_q, ss_prev_q, fdone_q;

  assign m_mode  = cfg.en && cfg.mstr;
  assign s_sel   = cfg.en && !cfg.mstr && !ss_n_i;
  assign start   = load && m_mode;
  assign s_fall  = s_sel && ss_prev_q;
  assign abort   = modf_ev || !cfg.en;
  assign run     = m_mode ? m_busy_q : (s_sel && !fdone_q);
  assign step_ev = m_mode ? tick : (sck_i != sck_prev_q);
  assign present = (start || s_fall) && !cfg.cpha;
  assign in_bit  = m_mode ? miso_i : mosi_i;
  assign busy    = m_mode ? m_busy_q : (s_sel && (mid || !cfg.cpha));

  spi_regfile #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done_ev(done), .ss_n_i(ss_n_i), .rx_data(rx_data),
    .cfg(cfg), .load(load), .modf_ev(modf_ev), .irq(irq_o)
  );

  spi_rate_gen #(.CNT_W(RCNT_W)) rate_i (
    .clk(clk), .rst_n(rst_n), .run(m_busy_q && m_mode),
    .rate(cfg.rate), .tick(tick)
  );

  spi_shift_core #(.NBITS(DW)) core_i (
    .clk(clk), .rst_n(rst_n), .cpha(cfg.cpha), .run(run),
    .edge_ev(step_ev), .load(load), .load_data(reg_wdata),
    .present(present), .in_bit(in_bit), .out_bit(out_bit),
    .last_edge(last_edge), .done(done), .mid(mid), .rx_data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy_q   <= 1'b0;
      sck_q      <= 1'b0;
      sck_prev_q <= 1'b0;
      ss_prev_q  <= 1'b1;
      fdone_q    <= 1'b0;
    end else begin
      sck_prev_q <= sck_i;
      ss_prev_q  <= ss_n_i;

      if (abort || last_edge) m_busy_q <= 1'b0;
      else if (start)         m_busy_q <= 1'b1;

      if (!m_busy_q)  sck_q <= cfg.cpol;
      else if (tick)  sck_q <= ~sck_q;

      if (!s_sel)                                  fdone_q <= 1'b0;
      else if (last_edge && !cfg.cpha && !m_mode)  fdone_q <= 1'b1;
    end
  end

  assign sck_o   = m_mode ? sck_q : cfg.cpol;
  assign sck_oe  = m_mode;
  assign mosi_o  = out_bit;
  assign mosi_oe = m_mode;
  assign miso_o  = out_bit;
  assign miso_oe = s_sel;

  // R3: a master byte always begins from the idle clock level
  a_r3_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_busy_q) |-> (sck_q == cfg.cpol));
  // R6: a deselected slave never drives MISO
  a_r6_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_i |-> !miso_oe);
  // R10: after a fault the pins are released and the byte is dropped
  a_r10_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    modf_ev |=> (!sck_oe && !mosi_oe && !m_busy_q));
endmodule

// File: tb/spi_port_ctl_tb_top.sv
`timescale 1ns/1ps
module spi_port_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       m_wr = 0, m_rd = 0, p_wr = 0, p_rd = 0;
  logic [1:0] m_addr = 0, p_addr = 0;
  logic [7:0] m_wdata = 0, p_wdata = 0, m_rdata, p_rdata;
  logic       m_irq, p_irq;
  logic       m_ss_n = 1, p_ss_n = 1;
  logic       m_sck_o, m_sck_oe, m_mosi_o, m_mosi_oe, m_miso_o, m_miso_oe;
  logic       p_sck_o, p_sck_oe, p_mosi_o, p_mosi_oe, p_miso_o, p_miso_oe;
  logic       m_miso_in;

  assign m_miso_in = p_miso_oe ? p_miso_o : 1'b1;

  spi_port_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(m_wr), .reg_rd(m_rd), .reg_addr(m_addr),
    .reg_wdata(m_wdata), .reg_rdata(m_rdata), .irq_o(m_irq), .ss_n_i(m_ss_n),
    .sck_i(1'b0), .sck_o(m_sck_o), .sck_oe(m_sck_oe),
    .mosi_i(1'b0), .mosi_o(m_mosi_o), .mosi_oe(m_mosi_oe),
    .miso_i(m_miso_in), .miso_o(m_miso_o), .miso_oe(m_miso_oe)
  );

  spi_port_ctl peer_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(p_wr), .reg_rd(p_rd), .reg_addr(p_addr),
    .reg_wdata(p_wdata), .reg_rdata(p_rdata), .irq_o(p_irq), .ss_n_i(p_ss_n),
    .sck_i(m_sck_o), .sck_o(p_sck_o), .sck_oe(p_sck_oe),
    .mosi_i(m_mosi_o), .mosi_o(p_mosi_o), .mosi_oe(p_mosi_oe),
    .miso_i(1'b0), .miso_o(p_miso_o), .miso_oe(p_miso_oe)
  );

  localparam logic [1:0] CTRL = 2'd0, STAT = 2'd1, DATA = 2'd2;
  int nchk = 0, nfail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input bit peer, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (peer) begin p_wr = 1; p_addr = a; p_wdata = d; end
    else      begin m_wr = 1; m_addr = a; m_wdata = d; end
    @(negedge clk);
    p_wr = 0; m_wr = 0;
  endtask

  task automatic bus_rd(input bit peer, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    if (peer) begin p_rd = 1; p_addr = a; end
    else      begin m_rd = 1; m_addr = a; end
    #1;
    d = peer ? p_rdata : m_rdata;
    @(negedge clk);
    p_rd = 0; m_rd = 0;
  endtask

  task automatic clear_flags(input bit peer);
    logic [7:0] t;
    bus_rd(peer, STAT, t);
    bus_rd(peer, DATA, t);
  endtask

  function automatic int half_of(input int r);
    return (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 8 : 16;
  endfunction

  // master write, then watch pins until irq
  task automatic run_xfer(input logic [7:0] mt, input int cpha,
                          output int cyc, output int tog, output logic [7:0] bits,
                          output logic endsck);
    logic prev;
    clear_flags(0);
    bus_wr(0, DATA, mt);
    cyc = 0; tog = 0; bits = 8'h00; prev = m_sck_o;
    while (!m_irq && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (m_sck_o !== prev) begin
        if ((tog % 2) == cpha) bits = {bits[6:0], m_mosi_o};
        tog++;
        prev = m_sck_o;
      end
    end
    endsck = m_sck_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] rd, mt, pt, bits;
    logic endsck;
    int cyc, tog;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_rd(0, CTRL, rd); check("R1 ctrl", rd, 0);
    bus_rd(0, STAT, rd); check("R1 status", rd, 0);
    check("R1 sck_oe", m_sck_oe, 0);
    check("R1 mosi_oe", m_mosi_oe, 0);
    check("R1 miso_oe", p_miso_oe, 0);

    // sweep all modes and rates
    for (int mode = 0; mode < 4; mode++) begin
      for (int rate = 0; rate < 4; rate++) begin
        for (int p = 0; p < 2; p++) begin
          int cpol, cpha, h;
          cpol = mode / 2; cpha = mode % 2; h = half_of(rate);
          mt = 8'h5A + 8'(mode * 53 + rate * 17 + p * 101);
          pt = ~mt ^ 8'(rate * 3 + p * 64);
          bus_wr(1, CTRL, 8'(1 | (cpol << 2) | (cpha << 3) | ((3 - rate) << 4)));
          bus_wr(0, CTRL, 8'(3 | (cpol << 2) | (cpha << 3) | (rate << 4)));
          clear_flags(1);
          bus_wr(1, DATA, pt);
          @(negedge clk);
          if (rate != 0) p_ss_n = 0;
          @(negedge clk);
          run_xfer(mt, cpha, cyc, tog, bits, endsck);
          check("R5 cycles to done", cyc, 16 * h + 1);
          check("R3 sck transitions", tog, 16);
          check("R3 sck back to idle", endsck, cpol);
          check("R4 mosi at sample edges", bits, mt);
          bus_rd(0, DATA, rd);
          check("R2 master received", rd, (rate == 0) ? 8'hFF : pt);
          if (rate != 0) begin
            bus_rd(1, DATA, rd);
            check("R7 slave received at master rate", rd, mt);
          end
          @(negedge clk);
          p_ss_n = 1;
        end
      end
    end

    // R6 MISO enable follows select
    bus_wr(1, CTRL, 8'h09);
    @(negedge clk); check("R6 miso_oe deselected", p_miso_oe, 0);
    p_ss_n = 0;
    @(negedge clk); check("R6 miso_oe selected", p_miso_oe, 1);
    p_ss_n = 1;
    @(negedge clk);

    // R8 phase-0 framing: one byte per select low period
    bus_wr(1, CTRL, 8'h01);
    bus_wr(0, CTRL, 8'h13);
    clear_flags(1);
    bus_wr(1, DATA, 8'h81);
    p_ss_n = 0;
    @(negedge clk);
    run_xfer(8'h42, 0, cyc, tog, bits, endsck);
    bus_rd(0, DATA, rd); check("R8 phase0 master rx", rd, 8'h81);
    bus_rd(1, STAT, rd);
    bus_rd(1, DATA, rd); check("R8 phase0 slave rx", rd, 8'h42);
    run_xfer(8'h99, 0, cyc, tog, bits, endsck);
    repeat (4) @(negedge clk);
    bus_rd(1, STAT, rd); check("R8 phase0 second byte ignored", rd & 8'h01, 0);
    bus_rd(1, DATA, rd); check("R8 phase0 slave rx kept", rd, 8'h42);
    p_ss_n = 1;
    @(negedge clk);

    // R8 phase-1 back-to-back bytes
    bus_wr(1, CTRL, 8'h09);
    bus_wr(0, CTRL, 8'h1B);
    clear_flags(1);
    bus_wr(1, DATA, 8'h3C);
    p_ss_n = 0;
    @(negedge clk);
    run_xfer(8'hC3, 1, cyc, tog, bits, endsck);
    repeat (4) @(negedge clk);
    bus_rd(1, STAT, rd);
    bus_rd(1, DATA, rd); check("R8 phase1 first byte", rd, 8'hC3);
    bus_wr(1, DATA, 8'h5A);
    run_xfer(8'h17, 1, cyc, tog, bits, endsck);
    repeat (4) @(negedge clk);
    bus_rd(0, DATA, rd); check("R8 phase1 master second rx", rd, 8'h5A);
    bus_rd(1, DATA, rd); check("R8 phase1 slave second rx", rd, 8'h17);
    p_ss_n = 1;
    @(negedge clk);

    // R9 collision, then R12/R13 clearing order
    bus_wr(1, CTRL, 8'h01);
    bus_wr(0, CTRL, 8'h23);
    clear_flags(1);
    clear_flags(0);
    bus_wr(1, DATA, 8'h96);
    p_ss_n = 0;
    @(negedge clk);
    bus_wr(0, DATA, 8'h69);
    repeat (20) @(negedge clk);
    bus_wr(0, DATA, 8'h55);
    cyc = 0;
    while (!m_irq && cyc < 1000) begin @(negedge clk); cyc++; end
    repeat (40) @(negedge clk);
    check("R9 no restart after collision", m_sck_o, 0);
    bus_rd(1, DATA, rd); check("R9 byte in flight kept", rd, 8'h69);
    bus_rd(0, DATA, rd); check("R9 master rx", rd, 8'h96);
    bus_rd(0, STAT, rd); check("R12 flags kept without prior status read", rd, 8'h03);
    check("R13 irq with done", m_irq, 1);
    bus_rd(0, DATA, rd);
    bus_rd(0, STAT, rd); check("R12 flags cleared by sequence", rd, 8'h00);
    check("R13 irq low after clear", m_irq, 0);
    p_ss_n = 1;
    @(negedge clk);

    // R10 mode fault mid-byte
    bus_wr(0, CTRL, 8'h33);
    clear_flags(0);
    bus_wr(0, DATA, 8'hF0);
    repeat (30) @(negedge clk);
    m_ss_n = 0;
    @(negedge clk);
    @(negedge clk);
    check("R10 sck_oe dropped", m_sck_oe, 0);
    check("R10 mosi_oe dropped", m_mosi_oe, 0);
    bus_rd(0, CTRL, rd); check("R10 enable and master cleared", rd & 8'h03, 0);
    check("R13 irq on fault", m_irq, 1);
    repeat (600) @(negedge clk);
    bus_rd(0, STAT, rd); check("R10 fault set, no done", rd, 8'h04);
    m_ss_n = 1;
    bus_rd(0, DATA, rd);

    // R11 select-ignore suppresses the fault
    bus_wr(0, CTRL, 8'h53);
    m_ss_n = 0;
    @(negedge clk);
    run_xfer(8'h24, 0, cyc, tog, bits, endsck);
    check("R11 transfer completes", cyc, 33);
    bus_rd(0, STAT, rd); check("R11 no fault", rd & 8'h04, 0);
    bus_rd(0, CTRL, rd); check("R11 still master", rd & 8'h03, 3);
    m_ss_n = 1;

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule